// File: doc/BRIEF.md
# Shared Counter Timer with Per-Core Compare Channels

This block is a memory-mapped global timer for a cluster of cores. One free-running up-counter serves every core. Each core also owns a compare register and a dedicated timer interrupt line. A core's line goes pending once the shared count reaches that core's compare value. The line stays pending until software writes that core's compare register again. Any value acknowledges, including the value already stored.

Requests arrive on a simple register bus. Each request carries an address, write data, a write flag and the ID of the requesting core. A core reaches its own compare through a local window, without naming itself. To program a different core's compare, it first writes a target ID into its own remote-select register and then uses the remote window. A configuration register reports the counter width as a code n, where the width is 32 + 4n bits. The same register holds a halt bit. The counter is held while the bit is set and runs once it is cleared. The count can be read as one 64-bit word, or as separate low and high 32-bit words. The split words are live values, so software must reread the high word to detect a carry between the two reads.

Three kinds of state machine make up the block. The bus engine has the states BUS_IDLE and BUS_REPLY. A read request moves it to BUS_REPLY, which lasts one cycle per read. Back-to-back reads keep it in BUS_REPLY, and any other cycle returns it to BUS_IDLE. The counter has the states CNT_HALTED and CNT_RUNNING. A configuration write with the halt bit at 0 moves it from CNT_HALTED to CNT_RUNNING. A configuration write with the halt bit at 1 moves it back. Each per-core compare channel has the states TMR_ARMED and TMR_PENDING. It moves from TMR_ARMED to TMR_PENDING when the count is at or above the compare value and the register is not being written in that cycle. A write to the compare register moves it from TMR_PENDING back to TMR_ARMED.

Top module: `shared_timer`

## Requirements
- R1: After reset the counter is halted and reads 0, every compare register holds all ones (40 bits with the default width code), no interrupt line is high and bus_rvalid is 0.
- R2: Address 0 is the configuration register. Reads return the halt bit at bit 0 and the width code n in bits 11:8, with every other bit 0. The counter and compare registers are 32 + 4n bits wide, and any bit above that width reads as 0.
- R3: While the halt bit is 1 the count holds its value. Writing 0 to bit 0 of address 0 starts the count, and it then rises by exactly one per clock. Writing 1 to bit 0 stops it again.
- R4: A read of address 1 returns the whole count. Address 2 returns bits 31:0 and address 3 returns bits 63:32, each zero-extended. Each word is the live count of the request cycle, with nothing latched between the two words. Read data appears on bus_rdata with bus_rvalid high in the cycle after the request.
- R5: Address 4 is the local compare window. Reads and writes there act on the compare register of the core named on bus_core, and never on another core's register.
- R6: Address 5 is the requester's own remote-select register, which holds a core ID. Address 6 reads and writes the compare register of the core selected there. Each core's selection is stored separately, so a write by one core leaves the other cores' selections unchanged.
- R7: A core's interrupt line rises at the clock edge after a cycle in which the count is greater than or equal to its compare value. It then stays high until that compare register is written.
- R8: Any write to a core's compare register clears that core's interrupt at the next edge, even when the written value equals the stored one. If the count is still at or above the new value, the line rises again one edge later.
- R9: Each core has its own interrupt line. Setting, holding or clearing one core's line never changes another core's line.
- R10: Reads of address 7 return 0. Writes to addresses 1, 2, 3 and 7 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Request valid for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 64 | Write data |
| bus_core | input | CORE_W (2) | ID of the requesting core |
| bus_rdata | output | 64 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| timer_irq | output | NUM_CORES (4) | Per-core timer interrupt lines |

## Verification
The assertions take for granted that bus_core names a core that exists. They also assume the counter does not wrap past its width during an interval in which a compare is being watched, because a wrap would make the at-or-above test fall back. The stimulus issues one request at a time from a valid core ID, with an idle cycle between requests. Every compare target it programs lies a short, known distance above the live count, and the count never comes near its top bit. The interrupt lines are compared in every cycle of each window against a model kept from the same bus traffic. This model includes the acknowledge that rewrites an unchanged value.

// File: rtl/shared_timer_pkg.sv
package shared_timer_pkg;

    typedef enum logic [2:0] {
        RA_CONFIG    = 3'd0,
        RA_COUNT     = 3'd1,
        RA_COUNT_LO  = 3'd2,
        RA_COUNT_HI  = 3'd3,
        RA_LOCAL_CMP = 3'd4,
        RA_OTHER_SEL = 3'd5,
        RA_OTHER_CMP = 3'd6,
        RA_SPARE     = 3'd7
    } reg_addr_e;

    typedef enum logic {
        BUS_IDLE,
        BUS_REPLY
    } bus_state_e;

    typedef enum logic {
        CNT_HALTED,
        CNT_RUNNING
    } cnt_state_e;

    typedef enum logic {
        TMR_ARMED,
        TMR_PENDING
    } tmr_state_e;

    localparam int DATA_W        = 64;
    localparam int CFG_HALT_BIT  = 0;
    localparam int CFG_WIDTH_LSB = 8;
    localparam int CFG_WIDTH_W   = 4;

endpackage

// File: rtl/shared_timer_counter.sv
module shared_timer_counter
    import shared_timer_pkg::*;
#(
    parameter int CNT_W = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt_wr,
    input  logic             halt_val,
    output logic             halted,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    cnt_state_e       state_q;
    cnt_state_e       state_d;
    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CNT_HALTED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CNT_HALTED: begin
                if (halt_wr && !halt_val) begin
                    state_d = CNT_RUNNING;
                end
            end
            CNT_RUNNING: begin
                if (halt_wr && halt_val) begin
                    state_d = CNT_HALTED;
                end
            end
            default: state_d = CNT_HALTED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (state_q == CNT_RUNNING) begin
            count_q <= count_q + ONE;
        end
    end

    always_comb begin
        halted = (state_q == CNT_HALTED);
        count  = count_q;
    end

    // R3: a halted counter keeps its value
    a_r3_hold_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(count_q));

    // R3: a running counter advances by exactly one
    a_r3_step_when_running: assert property (@(posedge clk) disable iff (!rst_n)
        !halted |=> (count_q == $past(count_q) + ONE));

endmodule

// File: rtl/shared_timer_cmp.sv
module shared_timer_cmp
    import shared_timer_pkg::*;
#(
    parameter int CNT_W = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cmp_value,
    output logic             irq
);

    tmr_state_e       state_q;
    tmr_state_e       state_d;
    logic [CNT_W-1:0] cmp_q;
    logic             reached;

    assign reached = (count >= cmp_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '1;
        end else if (cmp_wr) begin
            cmp_q <= cmp_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TMR_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TMR_ARMED: begin
                if (!cmp_wr && reached) begin
                    state_d = TMR_PENDING;
                end
            end
            TMR_PENDING: begin
                if (cmp_wr) begin
                    state_d = TMR_ARMED;
                end
            end
            default: state_d = TMR_ARMED;
        endcase
    end

    always_comb begin
        irq       = (state_q == TMR_PENDING);
        cmp_value = cmp_q;
    end

    // R8: any compare write acknowledges at the next edge
    a_r8_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_wr |=> !irq);

    // R7: reaching the compare value raises the line
    a_r7_reach_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_wr && (count >= cmp_value)) |=> irq);

    // R7: a pending line holds until a compare write
    a_r7_pending_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !cmp_wr) |=> irq);

    // R7: no line rises while the count is below the compare value
    a_r7_no_early_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && (count < cmp_value)) |=> !irq);

endmodule

// File: rtl/shared_timer_bus.sv
module shared_timer_bus
    import shared_timer_pkg::*;
#(
    parameter int NUM_CORES  = 4,
    parameter int CORE_W     = 2,
    parameter int CNT_W      = 40,
    parameter int WIDTH_CODE = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req,
    input  logic                       we,
    input  logic [2:0]                 addr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [CORE_W-1:0]          core,
    input  logic                       halted,
    input  logic [CNT_W-1:0]           count,
    input  logic [NUM_CORES*CNT_W-1:0] cmp_flat,
    output logic [NUM_CORES-1:0]       cmp_wr,
    output logic                       halt_wr,
    output logic                       halt_val,
    output logic [DATA_W-1:0]          rdata,
    output logic                       rvalid
);

    localparam int CORE_SLOTS = 1 << CORE_W;

    bus_state_e        state_q;
    bus_state_e        state_d;
    reg_addr_e         reg_sel;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] rd_mux;
    logic              core_ok;
    logic              rd_req;
    logic              wr_req;
    logic [CORE_W-1:0] remote_id;
    logic [CORE_W-1:0] sel_q   [CORE_SLOTS];
    logic [CNT_W-1:0]  cmp_arr [CORE_SLOTS];
    logic [DATA_W-1:0] count64;

    assign reg_sel   = reg_addr_e'(addr);
    assign core_ok   = (32'(core) < NUM_CORES);
    assign rd_req    = req && !we;
    assign wr_req    = req && we;
    assign remote_id = sel_q[core];
    assign count64   = DATA_W'(count);

    generate
        for (genvar s = 0; s < CORE_SLOTS; s++) begin : g_slot
            if (s < NUM_CORES) begin : g_real
                assign cmp_arr[s] = cmp_flat[s*CNT_W +: CNT_W];
                assign cmp_wr[s]  = wr_req && core_ok &&
                    (((reg_sel == RA_LOCAL_CMP) && (core == CORE_W'(s))) ||
                     ((reg_sel == RA_OTHER_CMP) && (remote_id == CORE_W'(s))));
            end else begin : g_absent
                assign cmp_arr[s] = '0;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sel_q[s] <= '0;
                end else if (wr_req && core_ok && (reg_sel == RA_OTHER_SEL) &&
                             (core == CORE_W'(s))) begin
                    sel_q[s] <= wdata[CORE_W-1:0];
                end
            end
        end
    endgenerate

    assign halt_wr  = wr_req && (reg_sel == RA_CONFIG);
    assign halt_val = wdata[CFG_HALT_BIT];

    always_comb begin
        rd_mux = '0;
        case (reg_sel)
            RA_CONFIG: begin
                rd_mux[CFG_HALT_BIT] = halted;
                rd_mux[CFG_WIDTH_LSB +: CFG_WIDTH_W] = CFG_WIDTH_W'(WIDTH_CODE);
            end
            RA_COUNT:     rd_mux = count64;
            RA_COUNT_LO:  rd_mux = {32'b0, count64[31:0]};
            RA_COUNT_HI:  rd_mux = {32'b0, count64[63:32]};
            RA_LOCAL_CMP: rd_mux = core_ok ? DATA_W'(cmp_arr[core]) : '0;
            RA_OTHER_SEL: rd_mux = core_ok ? DATA_W'(remote_id) : '0;
            RA_OTHER_CMP: rd_mux = core_ok ? DATA_W'(cmp_arr[remote_id]) : '0;
            default:      rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE:  state_d = rd_req ? BUS_REPLY : BUS_IDLE;
            BUS_REPLY: state_d = rd_req ? BUS_REPLY : BUS_IDLE;
            default:   state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_req) begin
            rdata_q <= rd_mux;
        end
    end

    always_comb begin
        rvalid = (state_q == BUS_REPLY);
        rdata  = rdata_q;
    end

    // R4: every read is answered in the next cycle
    a_r4_reply_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rvalid);

    // R4: no reply without a read
    a_r4_no_spurious_reply: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rvalid);

    // R6: a single write reaches at most one compare register
    a_r6_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmp_wr));

    // R10: a read never triggers a compare update
    a_r10_read_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (cmp_wr == '0));

endmodule

// File: rtl/shared_timer.sv
module shared_timer
    import shared_timer_pkg::*;
#(
    parameter int NUM_CORES  = 4,
    parameter int WIDTH_CODE = 2,
    localparam int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_req,
    input  logic                 bus_we,
    input  logic [2:0]           bus_addr,
    input  logic [63:0]          bus_wdata,
    input  logic [CORE_W-1:0]    bus_core,
    output logic [63:0]          bus_rdata,
    output logic                 bus_rvalid,
    output logic [NUM_CORES-1:0] timer_irq
);

    localparam int CNT_W = 32 + 4 * WIDTH_CODE;

    logic                       halted;
    logic                       halt_wr;
    logic                       halt_val;
    logic [CNT_W-1:0]           count;
    logic [NUM_CORES-1:0]       cmp_wr;
    logic [NUM_CORES*CNT_W-1:0] cmp_flat;
    logic                       unused_wdata;

    assign unused_wdata = ^bus_wdata;

    shared_timer_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .halt_wr  (halt_wr),
        .halt_val (halt_val),
        .halted   (halted),
        .count    (count)
    );

    generate
        for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
            shared_timer_cmp #(
                .CNT_W (CNT_W)
            ) u_cmp (
                .clk       (clk),
                .rst_n     (rst_n),
                .cmp_wr    (cmp_wr[c]),
                .cmp_wdata (bus_wdata[CNT_W-1:0]),
                .count     (count),
                .cmp_value (cmp_flat[c*CNT_W +: CNT_W]),
                .irq       (timer_irq[c])
            );
        end
    endgenerate

    shared_timer_bus #(
        .NUM_CORES  (NUM_CORES),
        .CORE_W     (CORE_W),
        .CNT_W      (CNT_W),
        .WIDTH_CODE (WIDTH_CODE)
    ) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (bus_req),
        .we       (bus_we),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .core     (bus_core),
        .halted   (halted),
        .count    (count),
        .cmp_flat (cmp_flat),
        .cmp_wr   (cmp_wr),
        .halt_wr  (halt_wr),
        .halt_val (halt_val),
        .rdata    (bus_rdata),
        .rvalid   (bus_rvalid)
    );

endmodule

// File: tb/shared_timer_test.sv
`timescale 1ns/1ps
module shared_timer_test;

    localparam int NC = 4;
    localparam int WC = 2;
    localparam int CW = 40;
    localparam logic [63:0] MASK = (64'd1 << CW) - 64'd1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [63:0] bus_wdata = 64'd0;
    logic [1:0]  bus_core = 2'd0;
    logic [63:0] bus_rdata;
    logic        bus_rvalid;
    logic [3:0]  timer_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [63:0] m_cnt;
    logic        m_stop;
    logic [63:0] m_cmp [NC];
    int          m_sel [NC];
    logic [3:0]  m_irq;

    logic [63:0] exp_q [$];
    string       tag_q [$];

    always #10 clk = ~clk;

    shared_timer uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_core   (bus_core),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .timer_irq  (timer_irq)
    );

    function automatic bit wr_hit(int i);
        return bus_req && bus_we &&
            (((bus_addr == 3'd4) && (int'(bus_core) == i)) ||
             ((bus_addr == 3'd6) && (m_sel[bus_core] == i)));
    endfunction

    // reference model built from the requirements
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt  <= 64'd0;
            m_stop <= 1'b1;
            m_irq  <= 4'd0;
            for (int i = 0; i < NC; i++) begin
                m_cmp[i] <= MASK;
                m_sel[i] <= 0;
            end
        end else begin
            if (!m_stop) m_cnt <= m_cnt + 64'd1;
            for (int i = 0; i < NC; i++) begin
                m_irq[i] <= wr_hit(i) ? 1'b0 : (m_irq[i] | (m_cnt >= m_cmp[i]));
                if (wr_hit(i)) m_cmp[i] <= bus_wdata & MASK;
            end
            if (bus_req && bus_we && bus_addr == 3'd0) m_stop <= bus_wdata[0];
            if (bus_req && bus_we && bus_addr == 3'd5) m_sel[bus_core] <= int'(bus_wdata[1:0]);
        end
    end

    function automatic logic [63:0] model_read(int core, logic [2:0] a);
        case (a)
            3'd0: return (64'(WC) << 8) | 64'(m_stop);
            3'd1: return m_cnt;
            3'd2: return {32'd0, m_cnt[31:0]};
            3'd3: return {32'd0, m_cnt[63:32]};
            3'd4: return m_cmp[core];
            3'd5: return 64'(m_sel[core]);
            3'd6: return m_cmp[m_sel[core]];
            default: return 64'd0;
        endcase
    endfunction

    task automatic bus_write(input int core, input logic [2:0] a, input logic [63:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_core = 2'(core); bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input int core, input logic [2:0] a, input string tag);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_core = 2'(core); bus_addr = a;
        exp_q.push_back(model_read(core, a));
        tag_q.push_back(tag);
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R4: reply without request, got %h expected none", bus_rdata);
            end else begin
                logic [63:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    errors++;
                    $display("FAIL %s: got %h expected %h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic check_irq(input string tag);
        checks++;
        if (timer_irq !== m_irq) begin
            errors++;
            $display("FAIL %s: timer_irq got %b expected %b", tag, timer_irq, m_irq);
        end
    endtask

    task automatic watch_irq(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check_irq(tag);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL ALL: watchdog got running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (timer_irq !== 4'd0 || bus_rvalid !== 1'b0) begin
            errors++;
            $display("FAIL R1: irq/rvalid got %b/%b expected 0000/0", timer_irq, bus_rvalid);
        end

        bus_read(0, 3'd0, "R1 R2 config at reset");
        bus_read(0, 3'd1, "R1 count at reset");
        repeat (3) @(negedge clk);
        bus_read(1, 3'd1, "R3 halted count holds");
        bus_read(2, 3'd4, "R1 compare all ones");
        bus_read(3, 3'd5, "R1 select zero");

        bus_write(0, 3'd1, 64'd55);
        bus_write(0, 3'd3, 64'd7);
        bus_write(0, 3'd7, 64'd9);
        bus_read(0, 3'd1, "R10 count writes ignored");
        bus_read(0, 3'd7, "R10 spare reads zero");

        bus_write(0, 3'd0, 64'd0);
        repeat (5) @(negedge clk);
        bus_read(1, 3'd1, "R3 running count");
        bus_read(1, 3'd2, "R4 low word");
        bus_read(1, 3'd3, "R4 high word");
        bus_read(2, 3'd0, "R2 config running");

        bus_write(0, 3'd0, 64'd1);
        bus_read(0, 3'd1, "R3 stopped count");
        repeat (4) @(negedge clk);
        bus_read(0, 3'd1, "R3 stopped count stable");
        bus_write(0, 3'd0, 64'd0);

        bus_write(3, 3'd4, 64'hFFFF_FFFF_FFFF_FFFF);
        bus_read(3, 3'd4, "R2 compare upper bits zero");

        bus_write(1, 3'd4, m_cnt + 64'd14);
        bus_read(0, 3'd4, "R5 core0 compare untouched");
        bus_read(1, 3'd4, "R5 core1 local compare");

        bus_write(0, 3'd5, 64'd2);
        bus_write(3, 3'd5, 64'd1);
        bus_write(0, 3'd6, m_cnt + 64'd28);
        bus_read(2, 3'd4, "R6 remote write reached core2");
        bus_read(3, 3'd6, "R6 remote read of core1");
        bus_read(0, 3'd5, "R6 core0 select kept");
        bus_read(3, 3'd5, "R6 core3 select kept");

        watch_irq(40, "R7 R9 independent lines");

        bus_write(1, 3'd4, m_cmp[1]);
        watch_irq(4, "R8 same-value acknowledge");
        bus_write(1, 3'd4, m_cnt + 64'd1000);
        watch_irq(6, "R8 acknowledge to later value");
        bus_write(0, 3'd6, m_cnt + 64'd2000);
        watch_irq(6, "R9 remote acknowledge core2 only");
        bus_write(2, 3'd4, m_cnt + 64'd6);
        watch_irq(12, "R7 local rearm core2");

        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R4: pending replies got %0d expected 0", exp_q.size());
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule